// File: doc/BRIEF.md
# Sequential Binary-to-Decimal Digit Converter

This block turns a 16-bit unsigned binary value into five packed decimal digits and, alongside them, the five matching printable ASCII characters. It does no shift-and-correct arithmetic. Instead it walks a fixed list of decimal weights, from the largest to the smallest. Every decade supplies the weights 8, 4, 2 and 1 times its power of ten. The ten-thousands decade drops its 8 weight, because 80000 exceeds any 16-bit input.

At each step the block compares the current weight with the remaining residue. If the weight fits, it subtracts the weight from the residue and sets the digit bit that the weight represents. One weight is handled per clock, so a conversion takes 19 clock cycles.

A caller pulses `conv_start` with `bin_value` while the block is idle. It then waits for the one-cycle `conv_done` pulse and reads `bcd_digits` or `ascii_chars`. Both outputs hold their value until the next accepted start.

Top module: `bcd_table_conv`

## Requirements
- R1: After reset, `conv_busy` and `conv_done` are 0 and `bcd_digits` is 0.
- R2: When `conv_start` is 1 at a rising edge while `conv_busy` is 0, the block captures `bin_value`, and `conv_busy` reads 1 after that edge.
- R3: `conv_done` rises exactly 19 rising edges after the accepting edge. It lasts one cycle, and `conv_busy` falls at the same edge.
- R4: At `conv_done`, nibble k of `bcd_digits` (bits 4k+3..4k) holds decimal digit k of the captured value, with nibble 0 holding the ones digit. Every nibble is in the range 0 to 9.
- R5: A weight equal to the remaining residue counts as fitting. Values that are exact multiples of a weight, such as 10, 1000, 20000 and 40000, therefore convert correctly.
- R6: Bit 19 of `bcd_digits` is always 0, and the ten-thousands digit never exceeds 6.
- R7: Byte k of `ascii_chars` (bits 8k+7..8k) equals 0x30 plus nibble k of `bcd_digits`.
- R8: A `conv_start` that arrives while `conv_busy` is 1 is ignored. The result and the timing of the conversion in progress are unchanged, including when the start arrives on the final busy cycle.
- R9: A `conv_start` given in the same cycle that `conv_done` is 1 is accepted and begins a new conversion.
- R10: The internal residue is zero when the walk finishes.
- R11: Between `conv_done` and the next accepted start, `bcd_digits` stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_start | input | 1 | Start request, taken only while idle |
| bin_value | input | 16 | Unsigned binary value captured on an accepted start |
| conv_busy | output | 1 | Conversion in progress |
| conv_done | output | 1 | One-cycle pulse when the digits are complete |
| bcd_digits | output | 20 | Packed decimal digits, ones in bits 3..0 |
| ascii_chars | output | 40 | ASCII digit characters, ones in bits 7..0 |

## Verification
Two events can share a cycle: the completion pulse and a fresh start request. The bench provokes this overlap in two ways. First, it raises the start request on the last busy cycle, where the start must be ignored and the finishing result must stay intact. Second, it raises the start request exactly in the `conv_done` cycle, where the start must be accepted. In each case the bench judges the finished digits against a decimal conversion it computes arithmetically. It also counts the cycles to the following done pulse, which must again be 19.

// File: rtl/bcd_conv_pkg.sv
package bcd_conv_pkg;

    localparam int WT_W = 32;

    function automatic logic [WT_W-1:0] pow10(input int exp);
        logic [WT_W-1:0] acc;
        acc = 1;
        for (int i = 0; i < exp; i++) acc = acc * 10;
        return acc;
    endfunction

    // Weight for digit bit k: (2 ** (k mod 4)) * 10 ** (k div 4); unused slots never fit.
    function automatic logic [WT_W-1:0] weight_of(input int k, input int entries);
        if (k >= entries) return '1;
        return pow10(k / 4) << (k % 4);
    endfunction

endpackage

// File: rtl/bcd_trial_sub.sv
module bcd_trial_sub
    import bcd_conv_pkg::*;
#(
    parameter int IN_W    = 16,
    parameter int ENTRIES = 19,
    parameter int IDX_W   = 5
) (
    input  logic [IN_W-1:0]  residue,
    input  logic [IDX_W-1:0] idx,
    output logic             fits,
    output logic [IN_W-1:0]  residue_next
);
    localparam int SLOTS = 2 ** IDX_W;

    logic [WT_W-1:0] wtab [SLOTS];
    logic [WT_W-1:0] wsel;

    generate
        for (genvar k = 0; k < SLOTS; k++) begin : g_wt
            assign wtab[k] = weight_of(k, ENTRIES);
        end
    endgenerate

    always_comb begin
        wsel         = wtab[idx];
        fits         = ({{(WT_W-IN_W){1'b0}}, residue} >= wsel);
        residue_next = fits ? (residue - wsel[IN_W-1:0]) : residue;
    end
endmodule

// File: rtl/bcd_ascii_enc.sv
module bcd_ascii_enc #(
    parameter int DIGITS = 5
) (
    input  logic [4*DIGITS-1:0] digits,
    output logic [8*DIGITS-1:0] chars
);
    generate
        for (genvar d = 0; d < DIGITS; d++) begin : g_chr
            assign chars[8*d +: 8] = 8'h30 + {4'h0, digits[4*d +: 4]};
        end
    endgenerate
endmodule

// File: rtl/bcd_table_conv.sv
module bcd_table_conv
    import bcd_conv_pkg::*;
#(
    parameter int IN_W   = 16,
    parameter int DIGITS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_start,
    input  logic [IN_W-1:0]     bin_value,
    output logic                conv_busy,
    output logic                conv_done,
    output logic [4*DIGITS-1:0] bcd_digits,
    output logic [8*DIGITS-1:0] ascii_chars
);
    localparam int BCD_W   = 4 * DIGITS;
    localparam int ENTRIES = BCD_W - 1;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [IDX_W-1:0] idx;
        logic [IN_W-1:0]  residue;
        logic [BCD_W-1:0] bcd;
    } conv_state_t;

    conv_state_t st_d, st_q;
    logic            step_fits;
    logic [IN_W-1:0] step_residue;

    bcd_trial_sub #(.IN_W(IN_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_trial (
        .residue      (st_q.residue),
        .idx          (st_q.idx),
        .fits         (step_fits),
        .residue_next (step_residue)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (conv_start) begin
                st_d.busy    = 1'b1;
                st_d.idx     = TOP_IDX;
                st_d.residue = bin_value;
                st_d.bcd     = '0;
            end
        end else begin
            st_d.bcd[st_q.idx] = step_fits;
            st_d.residue       = step_residue;
            if (st_q.idx == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx = st_q.idx - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign conv_busy  = st_q.busy;
    assign conv_done  = st_q.done;
    assign bcd_digits = st_q.bcd;

    bcd_ascii_enc #(.DIGITS(DIGITS)) u_ascii (
        .digits (st_q.bcd),
        .chars  (ascii_chars)
    );

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !conv_done); // R3
    AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> !conv_busy); // R3
    AST_RESIDUE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> (st_q.residue == '0)); // R10
    AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bcd_digits[BCD_W-1]); // R6
    AST_IDX_WALKS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_busy && st_q.idx != '0) |=> (conv_busy && st_q.idx == $past(st_q.idx) - 1'b1)); // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_busy && !$past(conv_busy) && !$past(conv_start)) |-> $stable(bcd_digits)); // R11

    generate
        for (genvar d = 0; d < DIGITS; d++) begin : g_chk
            AST_NIBBLE_DECIMAL: assert property (@(posedge clk) disable iff (!rst_n)
                conv_done |-> (bcd_digits[4*d +: 4] <= 4'd9)); // R4
        end
    endgenerate
endmodule

// File: tb/tb_bcd_table_conv.sv
`timescale 1ns/1ps
module tb_bcd_table_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_start = 1'b0;
    logic [15:0] bin_value = '0;
    logic        conv_busy, conv_done;
    logic [19:0] bcd_digits;
    logic [39:0] ascii_chars;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit timed_out = 1'b0;

    always #4 clk = ~clk;

    bcd_table_conv dut (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .bin_value(bin_value),
        .conv_busy(conv_busy), .conv_done(conv_done),
        .bcd_digits(bcd_digits), .ascii_chars(ascii_chars)
    );

    function automatic logic [19:0] ref_bcd(input int v);
        logic [19:0] r;
        int t;
        t = v;
        for (int d = 0; d < 5; d++) begin
            r[4*d +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic logic [39:0] ref_ascii(input int v);
        logic [39:0] r;
        int t;
        t = v;
        for (int d = 0; d < 5; d++) begin
            r[8*d +: 8] = 8'(48 + t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Wait for done from a negedge just after the accepting edge; returns cycle count.
    task automatic wait_done(output int n, input int stray_at, input logic [15:0] stray_val);
        n = 0;
        while (!conv_done && n < 100) begin
            if (n == stray_at) begin conv_start = 1'b1; bin_value = stray_val; end
            @(negedge clk);
            conv_start = 1'b0;
            n++;
        end
        if (n >= 100) timed_out = 1'b1;
    endtask

    task automatic convert(input int v, input int stray_at, input string req);
        int n;
        @(negedge clk);
        conv_start = 1'b1; bin_value = 16'(v);
        @(negedge clk);
        conv_start = 1'b0;
        wait_done(n, stray_at, ~16'(v));
        check(n == 19, "R3 latency", 40'(n), 40'd19);
        check(bcd_digits == ref_bcd(v), req, {20'h0, bcd_digits}, {20'h0, ref_bcd(v)}); // R4 R10
        check(ascii_chars == ref_ascii(v), "R7", ascii_chars, ref_ascii(v));
    endtask

    initial begin
        #1000000;
        $display("FAIL watchdog actual=running expected=finished");
        errors++;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        check(!conv_busy && !conv_done && bcd_digits == '0, "R1 reset",
              {20'h0, bcd_digits}, 40'h0);
        rst_n = 1'b1;

        // R2: busy after the accepting edge
        @(negedge clk);
        conv_start = 1'b1; bin_value = 16'd1234;
        @(negedge clk);
        conv_start = 1'b0;
        check(conv_busy && !conv_done, "R2 busy", {39'h0, conv_busy}, 40'h1);
        wait_done(n, -1, 16'h0);
        check(bcd_digits == ref_bcd(1234), "R2 value", {20'h0, bcd_digits}, {20'h0, ref_bcd(1234)});

        // R11: result held while idle
        repeat (5) @(negedge clk);
        check(bcd_digits == ref_bcd(1234) && !conv_done, "R11 hold", {20'h0, bcd_digits}, {20'h0, ref_bcd(1234)});

        // R5 R6: exact multiples, extremes
        convert(0, -1, "R4 zero");
        convert(65535, -1, "R6 max");
        check(bcd_digits[19:16] <= 4'd6, "R6 top digit", {36'h0, bcd_digits[19:16]}, 40'h6);
        for (int p = 1; p <= 10000; p *= 10) convert(p, -1, "R5 power of ten");
        convert(40000, -1, "R5 40000");
        convert(20000, -1, "R5 20000");
        convert(60000, -1, "R5 60000");
        convert(8000, -1, "R5 8000");
        convert(10, -1, "R5 ten");

        // R8: stray starts mid-walk and on the last busy cycle
        convert(54321, 5, "R8 mid-walk start");
        convert(9999, 18, "R8 last-cycle start");

        // R9: start in the done cycle
        @(negedge clk);
        conv_start = 1'b1; bin_value = 16'd777;
        @(negedge clk);
        conv_start = 1'b0;
        wait_done(n, -1, 16'h0);
        conv_start = 1'b1; bin_value = 16'd31416;
        @(negedge clk);
        conv_start = 1'b0;
        check(conv_busy, "R9 accepted", {39'h0, conv_busy}, 40'h1);
        wait_done(n, -1, 16'h0);
        check(n == 19, "R9 latency", 40'(n), 40'd19);
        check(bcd_digits == ref_bcd(31416), "R9 value", {20'h0, bcd_digits}, {20'h0, ref_bcd(31416)});

        // Sweep of low values and a strided walk
        for (int v = 0; v < 2000; v++) convert(v, -1, "R4 sweep");
        for (int v = 3; v < 65536; v += 997) convert(v, -1, "R4 stride");
        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            convert(int'(lfsr), -1, "R4 random");
        end

        if (timed_out) begin
            errors++;
            $display("FAIL R3 actual=no done expected=done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule